// File: doc/BRIEF.md
# Track command packet framer

This block turns one locomotive command into the framed bit sequence that a spread-spectrum track transmitter sends. A single start pulse captures an 8-bit engine number, a raw command bit vector and its length. From then on the framer hands out one framed bit each time the downstream chip spreader asks for the next bit. It raises a one-cycle completion pulse when the last bit of the frame has been taken.

A frame has six fields. It opens with a run of ones that lets the AC-coupled line settle. A single zero then marks where the data begins. Next comes the engine number increased by one, least significant bit first. A one separates the address from the command. The command bits follow in index order, and a second run of ones closes the frame. The lengths of both runs of ones are parameters. Between frames the output rests at logic 1, so the line stays at the preamble level.

Top module: `track_cmd_framer`

## Requirements
- R1: While reset is asserted and after it is released, `bit_o` is 1 and both `busy_o` and `done_o` are 0 until a start is accepted.
- R2: While idle, `bit_o` stays 1 and a `bit_req_i` strobe does not start or change anything.
- R3: A frame begins with `N_LEAD` ones, followed by exactly one 0 start bit.
- R4: After the start bit come 8 address bits. They carry (engine + 1) mod 256, least significant bit first, so engine 49 is sent as 0,1,0,0,1,1,0,0 and engine 255 as eight zeros.
- R5: After the address come a single 1 separator and then `cmd_len_i` command bits, with `cmd_i[0]` sent first. A length of 0 sends no command bits. A length above `CMD_MAX` is treated as `CMD_MAX`.
- R6: The frame ends with `N_TRAIL` ones.
- R7: Each `bit_req_i` strobe seen while busy consumes exactly the bit currently shown on `bit_o`. Without a strobe, `bit_o` holds its value.
- R8: `busy_o` rises in the cycle after an accepted start and stays high until the last bit is consumed. A `start_i` that arrives while busy is ignored and leaves the frame unchanged.
- R9: `done_o` is high for exactly one cycle: the cycle after the last trailing one is consumed, which is also the cycle in which `busy_o` falls.
- R10: With the default parameters, engine 49 and the 29-bit command 01000000000000001000000011000 (index 0 first) produce exactly the 64-bit frame 1111111111111110010011001010000000000000010000000110001111111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the engine number, the command and its length when idle |
| engine_i | input | 8 | Engine number |
| cmd_i | input | CMD_MAX | Raw command bits; index 0 is sent first |
| cmd_len_i | input | $clog2(CMD_MAX+1) | Number of command bits to send |
| bit_req_i | input | 1 | Strobe from the spreader that consumes the current bit |
| bit_o | output | 1 | Current framed bit; 1 when idle |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the frame's last bit is consumed |

## Verification
The bench instantiates the framer with its defaults: 15 leading ones, 10 trailing ones and a 32-bit command limit. These values allow the complete 64-bit whistle frame to be compared bit for bit. They also bring the full 32-bit command and the clamping of an oversized length within reach. Request strobes arrive back to back, at a fixed sparse rate and in a pseudo-random pattern, so that both holding and consuming the current bit are exercised. Further runs cover the address wrap at engine 255, an empty command, and a start pulse injected in the middle of a frame.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LEAD,
    FS_MARK,
    FS_ADDR,
    FS_SEP,
    FS_CMD,
    FS_TRAIL
  } frame_st_e;
endpackage

// File: rtl/tcf_addr_fmt.sv
module tcf_addr_fmt #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] engine_i,
  output logic [ADDR_W-1:0] addr_o
);
  // address field value is the engine number plus one, wrapping in the field width
  always_comb begin
    addr_o = engine_i + ADDR_W'(1);
  end
endmodule

// File: rtl/tcf_frame_seq.sv
module tcf_frame_seq
  import tcf_pkg::*;
#(
  parameter int N_LEAD  = 15,
  parameter int N_TRAIL = 10,
  parameter int ADDR_W  = 8,
  parameter int LW      = 6,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bit_req_i,
  input  logic [LW-1:0] len_q_i,
  output frame_st_e     st_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          done_o
);
  frame_st_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    load_o = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (start_i) begin
          st_d   = FS_LEAD;
          cnt_d  = '0;
          load_o = 1'b1;
        end
      end
      default: begin
        if (bit_req_i) begin
          cnt_d = cnt_q + CW'(1);
          case (st_q)
            FS_LEAD: if (cnt_q == CW'(N_LEAD - 1)) begin
              st_d  = FS_MARK;
              cnt_d = '0;
            end
            FS_MARK: begin
              st_d  = FS_ADDR;
              cnt_d = '0;
            end
            FS_ADDR: if (cnt_q == CW'(ADDR_W - 1)) begin
              st_d  = FS_SEP;
              cnt_d = '0;
            end
            FS_SEP: begin
              st_d  = (len_q_i == '0) ? FS_TRAIL : FS_CMD;
              cnt_d = '0;
            end
            FS_CMD: if (cnt_q == CW'(len_q_i) - CW'(1)) begin
              st_d  = FS_TRAIL;
              cnt_d = '0;
            end
            FS_TRAIL: if (cnt_q == CW'(N_TRAIL - 1)) begin
              st_d   = FS_IDLE;
              cnt_d  = '0;
              done_d = 1'b1;
            end
            default: begin
              st_d  = FS_IDLE;
              cnt_d = '0;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign st_o   = st_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/tcf_bit_sel.sv
module tcf_bit_sel
  import tcf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CMD_MAX = 32,
  parameter int CW      = 6
) (
  input  frame_st_e          st_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CMD_MAX-1:0] cmd_i,
  output logic               bit_o
);
  localparam int AIW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int CIW = (CMD_MAX > 1) ? $clog2(CMD_MAX) : 1;

  always_comb begin
    case (st_i)
      FS_MARK: bit_o = 1'b0;
      FS_ADDR: bit_o = addr_i[cnt_i[AIW-1:0]];
      FS_CMD:  bit_o = cmd_i[cnt_i[CIW-1:0]];
      default: bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/track_cmd_framer.sv
module track_cmd_framer
  import tcf_pkg::*;
#(
  parameter int N_LEAD  = 15,
  parameter int N_TRAIL = 10,
  parameter int CMD_MAX = 32,
  localparam int ADDR_W = 8,
  localparam int LW     = $clog2(CMD_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  engine_i,
  input  logic [CMD_MAX-1:0] cmd_i,
  input  logic [LW-1:0]      cmd_len_i,
  input  logic               bit_req_i,
  output logic               bit_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int M1   = (N_LEAD > N_TRAIL) ? N_LEAD : N_TRAIL;
  localparam int M2   = (CMD_MAX > ADDR_W) ? CMD_MAX : ADDR_W;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0]  addr_d, addr_q;
  logic [CMD_MAX-1:0] cmd_q;
  logic [LW-1:0]      len_d, len_q;
  frame_st_e          st;
  logic [CW-1:0]      cnt;
  logic               load_en;

  tcf_addr_fmt #(.ADDR_W(ADDR_W)) u_addr (
    .engine_i (engine_i),
    .addr_o   (addr_d)
  );

  assign len_d = (cmd_len_i > LW'(CMD_MAX)) ? LW'(CMD_MAX) : cmd_len_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
      len_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_d;
      cmd_q  <= cmd_i;
      len_q  <= len_d;
    end
  end

  tcf_frame_seq #(
    .N_LEAD (N_LEAD),
    .N_TRAIL(N_TRAIL),
    .ADDR_W (ADDR_W),
    .LW     (LW),
    .CW     (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .bit_req_i (bit_req_i),
    .len_q_i   (len_q),
    .st_o      (st),
    .cnt_o     (cnt),
    .load_o    (load_en),
    .done_o    (done_o)
  );

  tcf_bit_sel #(
    .ADDR_W (ADDR_W),
    .CMD_MAX(CMD_MAX),
    .CW     (CW)
  ) u_sel (
    .st_i   (st),
    .cnt_i  (cnt),
    .addr_i (addr_q),
    .cmd_i  (cmd_q),
    .bit_o  (bit_o)
  );

  assign busy_o = (st != FS_IDLE);
endmodule

// File: rtl/track_cmd_framer_chk.sv
module track_cmd_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic bit_req_i,
  input logic bit_o,
  input logic busy_o,
  input logic done_o
);
  p_idle_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> bit_o);

  p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bit_req_i) |=> $stable(bit_o));

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bit_req_i) |=> busy_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o) && $past(bit_req_i)));
endmodule

bind track_cmd_framer track_cmd_framer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .bit_req_i (bit_req_i),
  .bit_o     (bit_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/sim_track_cmd_framer.sv
module sim_track_cmd_framer;
  localparam int N_LEAD  = 15;
  localparam int N_TRAIL = 10;
  localparam int CMD_MAX = 32;
  localparam int LW      = $clog2(CMD_MAX + 1);

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [7:0]         engine_i;
  logic [CMD_MAX-1:0] cmd_i;
  logic [LW-1:0]      cmd_len_i;
  logic               bit_req_i;
  logic               bit_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit live   = 0;
  bit m_done = 0;
  bit q[$];
  bit rx[$];
  logic [7:0] lf = 8'h5a;

  track_cmd_framer #(.N_LEAD(N_LEAD), .N_TRAIL(N_TRAIL), .CMD_MAX(CMD_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .engine_i(engine_i),
    .cmd_i(cmd_i), .cmd_len_i(cmd_len_i), .bit_req_i(bit_req_i),
    .bit_o(bit_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference model: queue of bits still to send, built from the requirements
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_done = 0;
    end else begin
      bit was_busy;
      was_busy = (q.size() > 0);
      m_done = 0;
      if (was_busy && bit_req_i) begin
        rx.push_back(q.pop_front());
        if (q.size() == 0) m_done = 1;
      end else if (!was_busy && start_i) begin
        int len;
        logic [7:0] a;
        len = (int'(cmd_len_i) > CMD_MAX) ? CMD_MAX : int'(cmd_len_i);
        a = engine_i + 8'd1;
        rx.delete();
        for (int i = 0; i < N_LEAD; i++) q.push_back(1'b1);
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) q.push_back(a[i]);
        q.push_back(1'b1);
        for (int i = 0; i < len; i++) q.push_back(cmd_i[i]);
        for (int i = 0; i < N_TRAIL; i++) q.push_back(1'b1);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      bit eb;
      eb = (q.size() > 0) ? q[0] : 1'b1;
      chk(bit_o === eb, "R3/R4/R5/R6/R7 bit_o", int'(bit_o), int'(eb));
      chk(busy_o === (q.size() > 0), "R8 busy_o", int'(busy_o), int'(q.size() > 0));
      chk(done_o === m_done, "R9 done_o", int'(done_o), int'(m_done));
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // mode 0: every cycle, 1: every third cycle, 2: pseudo-random
  task automatic send(input logic [7:0] eng, input logic [CMD_MAX-1:0] cmd,
                      input int len, input int mode, input int stray_at);
    int n = 0;
    @(negedge clk);
    engine_i  = eng;
    cmd_i     = cmd;
    cmd_len_i = LW'(len);
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    engine_i  = ~eng;
    cmd_i     = ~cmd;
    forever begin
      n++;
      start_i = (n == stray_at);
      case (mode)
        0: bit_req_i = 1'b1;
        1: bit_req_i = (n % 3 == 0);
        default: begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          bit_req_i = lf[0];
        end
      endcase
      @(negedge clk);
      if (done_o) break;
    end
    bit_req_i = 1'b0;
    start_i   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int flen(input int len);
    return N_LEAD + 1 + 8 + 1 + len + N_TRAIL;
  endfunction

  initial begin
    logic [63:0] pkt;
    logic [CMD_MAX-1:0] wcmd;
    logic [7:0] a;
    rst_n = 1'b0; start_i = 1'b0; engine_i = '0; cmd_i = '0;
    cmd_len_i = '0; bit_req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(bit_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        int'({bit_o, busy_o, done_o}), 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;
    chk(bit_o === 1'b1 && busy_o === 1'b0, "R1 after release", int'({bit_o, busy_o}), 2);

    // R2: strobes while idle do nothing
    bit_req_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy_o === 1'b0 && bit_o === 1'b1, "R2 idle strobe", int'({bit_o, busy_o}), 2);
    bit_req_i = 1'b0;
    @(negedge clk);

    // R10: whistle frame for engine 49
    pkt = 64'b1111111111111110010011001010000000000000010000000110001111111111;
    wcmd = '0;
    for (int k = 0; k < 29; k++) wcmd[k] = pkt[63 - (25 + k)];
    send(8'd49, wcmd, 29, 0, 0);
    chk(rx.size() == 64, "R10 frame length", rx.size(), 64);
    for (int i = 0; i < 64 && i < rx.size(); i++)
      chk(rx[i] === pkt[63 - i], "R10 frame bit", int'(rx[i]), int'(pkt[63 - i]));
    for (int i = 0; i < 8 && 16 + i < rx.size(); i++)
      chk(rx[16 + i] === pkt[63 - 16 - i], "R4 address LSB first", int'(rx[16 + i]), int'(pkt[47 - i]));

    // R4: engine 255 wraps to address zero, sparse strobes
    send(8'd255, 32'hdead_beef, 12, 1, 0);
    a = '0;
    for (int i = 0; i < 8 && 16 + i < rx.size(); i++) a[i] = rx[16 + i];
    chk(a == 8'd0, "R4 wrap of 255", int'(a), 0);
    chk(rx.size() == flen(12), "R5 length 12", rx.size(), flen(12));

    // R5: empty command goes separator straight to trailer
    send(8'd3, 32'hffff_ffff, 0, 2, 0);
    chk(rx.size() == flen(0), "R5 zero length", rx.size(), flen(0));
    chk(rx.size() > N_LEAD && rx[N_LEAD] === 1'b0, "R3 start bit", int'(rx[N_LEAD]), 0);

    // R5: full width and oversized length clamped
    send(8'd100, 32'h8000_0001, 32, 2, 0);
    chk(rx.size() == flen(32), "R5 full 32 bits", rx.size(), flen(32));
    send(8'd7, 32'h1234_5678, 40, 0, 0);
    chk(rx.size() == flen(32), "R5 clamp above max", rx.size(), flen(32));

    // R8: start pulse in mid-frame is ignored
    send(8'd20, 32'h0000_00f0, 10, 1, 30);
    a = '0;
    for (int i = 0; i < 8 && 16 + i < rx.size(); i++) a[i] = rx[16 + i];
    chk(a == 8'd21, "R8 stray start ignored", int'(a), 21);
    chk(rx.size() == flen(10), "R8 length kept", rx.size(), flen(10));
    chk(busy_o === 1'b0, "R8 idle after frame", int'(busy_o), 0);

    // R6: trailing run is all ones
    for (int i = 0; i < N_TRAIL && rx.size() >= N_TRAIL; i++)
      chk(rx[rx.size() - 1 - i] === 1'b1, "R6 trailing one", int'(rx[rx.size() - 1 - i]), 1);

    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule